// File: doc/BRIEF.md
# Four-Point Cosine Transform Butterfly

This block turns a vector of four signed samples into four cosine-transform coefficients. It does not multiply a full 4×4 matrix. A two-stage butterfly does the work instead. The first stage forms sums and differences of mirrored input pairs, meaning the outer pair and the inner pair. The second stage weights those terms with three constant cosine fractions. The whole transform needs six constant products.

One vector can be presented on every clock, marked by a valid strobe. There is no backpressure. The coefficients come out in natural index order after a fixed three-cycle pipeline. They are computed at full precision and then rounded once to the output width. A caller typically uses two of these blocks, with a transpose store between them, to build a separable two-dimensional transform. That surrounding logic is not part of this block.

Top module: `dct4_butterfly`

## Requirements
- R1: The inputs are paired mirror-wise: s_out = x0 + x3, d_out = x0 − x3, s_in = x1 + x2, d_in = x1 − x2. An input at index 0 and an input at index 3 therefore give the same even coefficients, and their odd coefficients have opposite sign except for rounding.
- R2: Coefficient y0 equals round((s_out + s_in)·K2 / 2048).
- R3: Coefficient y2 equals round((s_out − s_in)·K2 / 2048).
- R4: Coefficient y1 equals round((d_out·K1 + d_in·K3) / 2048).
- R5: Coefficient y3 equals round((d_out·K3 − d_in·K1) / 2048).
- R6: The constants are 12-bit signed fractions with 11 fraction bits, Kk = round(2048·cos(kπ/8)/√2). This gives K1 = 1338, K2 = 1024 and K3 = 554. Six products are formed for each vector.
- R7: Rounding is half-up on the full-precision sum: y = floor((s + 1024) / 2048). For example, an exact +0.5 becomes 1 and an exact −0.5 becomes 0. The result is the 16-bit signed value.
- R8: out_vld rises exactly 3 clock edges after the edge that samples in_vld high. The y ports are valid in the same cycle as out_vld.
- R9: A new vector is accepted on every cycle. Back-to-back vectors each produce their own result on consecutive cycles.
- R10: Synchronous active-high reset clears only the valid pipeline. out_vld is low during reset and stays low for vectors that were in flight when reset was applied.
- R11: Every output lies within 1.5 LSB of the real-valued transform X_k = Σ x_n·cos((2n+1)kπ/8)/√2, with X_0 scaled by 1/√2 in addition.
- R12: The outputs appear in natural order: y0 is the DC term, y1 is the first odd term, y2 is the second even term and y3 is the highest-frequency term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_vld | input | 1 | Input vector strobe |
| in_x0 | input | 12 | Sample 0, signed |
| in_x1 | input | 12 | Sample 1, signed |
| in_x2 | input | 12 | Sample 2, signed |
| in_x3 | input | 12 | Sample 3, signed |
| out_vld | output | 1 | Coefficient strobe |
| out_y0 | output | 16 | DC coefficient, signed |
| out_y1 | output | 16 | Coefficient 1, signed |
| out_y2 | output | 16 | Coefficient 2, signed |
| out_y3 | output | 16 | Coefficient 3, signed |

## Verification
All four coefficients of a vector sampled at clock edge n, together with out_vld, are due after edge n+3. Stimulus is driven on falling edges. On each falling edge the bench first compares the outputs with the record it kept three cycles earlier, and only then drives the next vector. That record is written only where the bench itself expects a result, so the comparison stays aligned under a dense valid stream, under gaps, and across a reset that flushes vectors still in flight. Each result is checked two ways: bit-exactly against an integer model of the stated fixed-point formula, and within a tolerance against a real-valued cosine model.

// File: rtl/dct4_pkg.sv
package dct4_pkg;

    localparam int DIN_W  = 12;
    localparam int COEF_W = 12;
    localparam int FRAC_W = 11;
    localparam int DOUT_W = 16;
    localparam int LAT    = 3;

    // Q1.11 weights: round(2048 * cos(k*pi/8) / sqrt(2))
    localparam int K1_DEF = 1338;
    localparam int K2_DEF = 1024;
    localparam int K3_DEF = 554;

    localparam int SUM_W = DIN_W + 1;
    localparam int ACC_W = SUM_W + 1 + COEF_W + 1;

    typedef struct packed {
        logic signed [SUM_W-1:0] s_out;
        logic signed [SUM_W-1:0] d_out;
        logic signed [SUM_W-1:0] s_in;
        logic signed [SUM_W-1:0] d_in;
    } pair_t;

    typedef struct packed {
        logic signed [ACC_W-1:0] ev_sum;
        logic signed [ACC_W-1:0] ev_dif;
        logic signed [ACC_W-1:0] do_k1;
        logic signed [ACC_W-1:0] di_k3;
        logic signed [ACC_W-1:0] do_k3;
        logic signed [ACC_W-1:0] di_k1;
    } prod_t;

    typedef struct packed {
        logic signed [DOUT_W-1:0] y0;
        logic signed [DOUT_W-1:0] y1;
        logic signed [DOUT_W-1:0] y2;
        logic signed [DOUT_W-1:0] y3;
    } coef_t;

    function automatic logic signed [DOUT_W-1:0] round_half_up(
        input logic signed [ACC_W-1:0] s
    );
        logic signed [ACC_W-1:0] t;
        t = (s + ACC_W'(1 <<< (FRAC_W - 1))) >>> FRAC_W;
        return t[DOUT_W-1:0];
    endfunction

endpackage

// File: rtl/dct4_pre.sv
module dct4_pre
    import dct4_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [DIN_W-1:0] x0,
    input  logic signed [DIN_W-1:0] x1,
    input  logic signed [DIN_W-1:0] x2,
    input  logic signed [DIN_W-1:0] x3,
    output pair_t                   q
);

    // Mirrored pairing: outer pair (0,3), inner pair (1,2)
    always_ff @(posedge clk) begin
        q.s_out <= SUM_W'(x0) + SUM_W'(x3);
        q.d_out <= SUM_W'(x0) - SUM_W'(x3);
        q.s_in  <= SUM_W'(x1) + SUM_W'(x2);
        q.d_in  <= SUM_W'(x1) - SUM_W'(x2);
    end

    AST_OUTER_PAIR: assert property (@(posedge clk) disable iff (rst)
        (q.s_out + q.d_out) == (SUM_W'($past(x0)) <<< 1)); // R1
    AST_INNER_PAIR: assert property (@(posedge clk) disable iff (rst)
        (q.s_in - q.d_in) == (SUM_W'($past(x2)) <<< 1)); // R1

endmodule

// File: rtl/dct4_mul.sv
module dct4_mul
    import dct4_pkg::*;
#(
    parameter int K1 = K1_DEF,
    parameter int K2 = K2_DEF,
    parameter int K3 = K3_DEF
) (
    input  logic  clk,
    input  logic  rst,
    input  pair_t d,
    output prod_t q
);

    localparam logic signed [ACC_W-1:0] W1 = ACC_W'(K1);
    localparam logic signed [ACC_W-1:0] W2 = ACC_W'(K2);
    localparam logic signed [ACC_W-1:0] W3 = ACC_W'(K3);

    logic signed [ACC_W-1:0] ev_a;
    logic signed [ACC_W-1:0] ev_b;
    logic signed [ACC_W-1:0] od_o;
    logic signed [ACC_W-1:0] od_i;

    always_comb begin
        ev_a = ACC_W'(d.s_out) + ACC_W'(d.s_in);
        ev_b = ACC_W'(d.s_out) - ACC_W'(d.s_in);
        od_o = ACC_W'(d.d_out);
        od_i = ACC_W'(d.d_in);
    end

    // Six constant products per vector
    always_ff @(posedge clk) begin
        q.ev_sum <= ev_a * W2;
        q.ev_dif <= ev_b * W2;
        q.do_k1  <= od_o * W1;
        q.di_k3  <= od_i * W3;
        q.do_k3  <= od_o * W3;
        q.di_k1  <= od_i * W1;
    end

    AST_EVEN_SPLIT: assert property (@(posedge clk) disable iff (rst)
        (q.ev_sum - q.ev_dif) == (ACC_W'($past(d.s_in)) * W2 * ACC_W'(2))); // R3

endmodule

// File: rtl/dct4_post.sv
module dct4_post
    import dct4_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  prod_t d,
    output coef_t q
);

    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1 <<< (FRAC_W - 1));

    logic signed [ACC_W-1:0] odd1;
    logic signed [ACC_W-1:0] odd3;

    always_comb begin
        odd1 = d.do_k1 + d.di_k3;
        odd3 = d.do_k3 - d.di_k1;
    end

    always_ff @(posedge clk) begin
        q.y0 <= round_half_up(d.ev_sum);
        q.y1 <= round_half_up(odd1);
        q.y2 <= round_half_up(d.ev_dif);
        q.y3 <= round_half_up(odd3);
    end

    AST_ROUND_LO_Y1: assert property (@(posedge clk) disable iff (rst)
        ($past(odd1) - (ACC_W'(q.y1) <<< FRAC_W)) >= -HALF); // R7
    AST_ROUND_HI_Y1: assert property (@(posedge clk) disable iff (rst)
        ($past(odd1) - (ACC_W'(q.y1) <<< FRAC_W)) < HALF); // R7
    AST_ROUND_LO_Y0: assert property (@(posedge clk) disable iff (rst)
        ($past(d.ev_sum) - (ACC_W'(q.y0) <<< FRAC_W)) >= -HALF); // R7
    AST_ROUND_HI_Y0: assert property (@(posedge clk) disable iff (rst)
        ($past(d.ev_sum) - (ACC_W'(q.y0) <<< FRAC_W)) < HALF); // R7

endmodule

// File: rtl/dct4_butterfly.sv
module dct4_butterfly
    import dct4_pkg::*;
#(
    parameter int K1 = K1_DEF,
    parameter int K2 = K2_DEF,
    parameter int K3 = K3_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_vld,
    input  logic signed [DIN_W-1:0]  in_x0,
    input  logic signed [DIN_W-1:0]  in_x1,
    input  logic signed [DIN_W-1:0]  in_x2,
    input  logic signed [DIN_W-1:0]  in_x3,
    output logic                     out_vld,
    output logic signed [DOUT_W-1:0] out_y0,
    output logic signed [DOUT_W-1:0] out_y1,
    output logic signed [DOUT_W-1:0] out_y2,
    output logic signed [DOUT_W-1:0] out_y3
);

    pair_t pairs;
    prod_t prods;
    coef_t coefs;
    logic [LAT-1:0] vld_sr;

    dct4_pre u_pre (
        .clk (clk),
        .rst (rst),
        .x0  (in_x0),
        .x1  (in_x1),
        .x2  (in_x2),
        .x3  (in_x3),
        .q   (pairs)
    );

    dct4_mul #(.K1(K1), .K2(K2), .K3(K3)) u_mul (
        .clk (clk),
        .rst (rst),
        .d   (pairs),
        .q   (prods)
    );

    dct4_post u_post (
        .clk (clk),
        .rst (rst),
        .d   (prods),
        .q   (coefs)
    );

    // Valid pipeline: one stage per data register stage
    genvar g;
    generate
        for (g = 0; g < LAT; g++) begin : g_vld
            always_ff @(posedge clk) begin
                if (rst)
                    vld_sr[g] <= 1'b0;
                else if (g == 0)
                    vld_sr[g] <= in_vld;
                else
                    vld_sr[g] <= vld_sr[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign out_vld = vld_sr[LAT-1];
    assign out_y0  = coefs.y0;
    assign out_y1  = coefs.y1;
    assign out_y2  = coefs.y2;
    assign out_y3  = coefs.y3;

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
        in_vld |-> ##3 out_vld); // R8
    AST_IDLE_DELAY: assert property (@(posedge clk) disable iff (rst)
        !in_vld |-> ##3 !out_vld); // R9
    AST_RESET_FLUSH: assert property (@(posedge clk)
        $past(rst) |-> !out_vld); // R10

endmodule

// File: tb/dct4_butterfly_test.sv
module dct4_butterfly_test;

    localparam int NC = 2000;
    localparam real PI = 3.14159265358979323846;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_vld = 1'b0;
    logic signed [11:0] in_x0 = '0, in_x1 = '0, in_x2 = '0, in_x3 = '0;
    logic out_vld;
    logic signed [15:0] out_y0, out_y1, out_y2, out_y3;

    always #4 clk = ~clk;

    dct4_butterfly uut (
        .clk(clk), .rst(rst), .in_vld(in_vld),
        .in_x0(in_x0), .in_x1(in_x1), .in_x2(in_x2), .in_x3(in_x3),
        .out_vld(out_vld),
        .out_y0(out_y0), .out_y1(out_y1), .out_y2(out_y2), .out_y3(out_y3)
    );

    int    hx [NC][4];
    bit    hv [NC];
    bit    hf [NC];
    bit    hl [NC];
    int    hy [NC][4];
    string ht [NC];
    int    cyc  = 0;
    int    errs = 0;
    int    chks = 0;
    bit    done = 1'b0;

    function automatic longint rnd(input longint s);
        return (s + 1024) >>> 11;
    endfunction

    // Integer model built from R1..R7
    function automatic int model(input int k, input int a, input int b, input int c, input int d);
        longint so, dd, si, di;
        so = a + d; dd = a - d; si = b + c; di = b - c;
        case (k)
            0: return int'(rnd((so + si) * 1024));
            1: return int'(rnd(dd * 1338 + di * 554));
            2: return int'(rnd((so - si) * 1024));
            default: return int'(rnd(dd * 554 - di * 1338));
        endcase
    endfunction

    // Real-valued cosine transform (R11)
    function automatic real rmodel(input int k, input int a, input int b, input int c, input int d);
        real acc;
        int  xv [4];
        xv[0] = a; xv[1] = b; xv[2] = c; xv[3] = d;
        acc = 0.0;
        for (int n = 0; n < 4; n++)
            acc += xv[n] * $cos((2 * n + 1) * k * PI / 8.0) / $sqrt(2.0);
        if (k == 0) acc = acc / $sqrt(2.0);
        return acc;
    endfunction

    task automatic chk_int(input string what, input int act, input int exp);
        chks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic check_out(input int k);
        int  j;
        int  yv [4];
        real r, df;
        yv[0] = int'(out_y0); yv[1] = int'(out_y1);
        yv[2] = int'(out_y2); yv[3] = int'(out_y3);
        if (k < 3) begin
            chk_int("R10 out_vld during reset", int'(out_vld), 0);
            return;
        end
        j = k - 3;
        chk_int(hf[j] ? "R10 out_vld after flush" : "R8 out_vld latency", int'(out_vld), int'(hv[j]));
        if (!hv[j]) return;
        chk_int({ht[j], " R2 y0"}, yv[0], model(0, hx[j][0], hx[j][1], hx[j][2], hx[j][3]));
        chk_int({ht[j], " R4 y1"}, yv[1], model(1, hx[j][0], hx[j][1], hx[j][2], hx[j][3]));
        chk_int({ht[j], " R3 y2"}, yv[2], model(2, hx[j][0], hx[j][1], hx[j][2], hx[j][3]));
        chk_int({ht[j], " R5 y3"}, yv[3], model(3, hx[j][0], hx[j][1], hx[j][2], hx[j][3]));
        for (int q = 0; q < 4; q++) begin
            r  = rmodel(q, hx[j][0], hx[j][1], hx[j][2], hx[j][3]);
            df = yv[q] - r;
            chks++;
            if (df > 1.5 || df < -1.5) begin
                errs++;
                $display("FAIL R11 y%0d actual=%0d expected=%f", q, yv[q], r);
            end
        end
        if (hl[j])
            for (int q = 0; q < 4; q++)
                chk_int($sformatf("%s literal y%0d", ht[j], q), yv[q], hy[j][q]);
    endtask

    task automatic step(input bit v, input int a, input int b, input int c, input int d,
                        input string tag, input bit r);
        @(negedge clk);
        check_out(cyc);
        rst    = r;
        in_vld = v;
        in_x0  = 12'(a); in_x1 = 12'(b); in_x2 = 12'(c); in_x3 = 12'(d);
        hx[cyc][0] = a; hx[cyc][1] = b; hx[cyc][2] = c; hx[cyc][3] = d;
        hv[cyc] = v & ~r;
        hf[cyc] = r;
        hl[cyc] = 1'b0;
        ht[cyc] = tag;
        if (r) begin
            for (int t = 1; t <= 2; t++)
                if (cyc - t >= 0 && hv[cyc - t]) begin
                    hv[cyc - t] = 1'b0;
                    hf[cyc - t] = 1'b1;
                end
        end
        cyc++;
    endtask

    task automatic lit(input int a, input int b, input int c, input int d, input string tag,
                       input int e0, input int e1, input int e2, input int e3);
        step(1'b1, a, b, c, d, tag, 1'b0);
        hl[cyc-1] = 1'b1;
        hy[cyc-1][0] = e0; hy[cyc-1][1] = e1; hy[cyc-1][2] = e2; hy[cyc-1][3] = e3;
    endtask

    function automatic int rs();
        return int'($urandom % 4096) - 2048;
    endfunction

    initial begin
        void'($urandom(32'd20241));
        for (int i = 0; i < 5; i++) step(1'b0, 0, 0, 0, 0, "R10 reset", 1'b1);
        step(1'b0, 0, 0, 0, 0, "idle", 1'b0);
        lit(2047, 0, 0, 0, "R6 coef", 1024, 1337, 1024, 554);
        lit(0, 0, 0, 2047, "R1 mirror", 1024, -1337, 1024, -554);
        lit(1, 0, 0, 0, "R7 half-up", 1, 1, 1, 0);
        lit(-1, 0, 0, 0, "R7 half-up neg", 0, -1, 0, 0);
        lit(-2048, -2048, -2048, -2048, "R2 min", -4096, 0, 0, 0);
        lit(2047, 2047, 2047, 2047, "R2 max", 4094, 0, 0, 0);
        lit(2047, -2048, 2047, -2048, "R12 order", -1, 1568, 0, 3783);
        for (int i = 0; i < 1500; i++)
            step(($urandom % 8) != 0, rs(), rs(), rs(), rs(), "R9 stream", 1'b0);
        for (int i = 0; i < 4; i++) step(1'b1, rs(), rs(), rs(), rs(), "R9 pre-reset", 1'b0);
        step(1'b1, rs(), rs(), rs(), rs(), "R10 mid reset", 1'b1);
        for (int i = 0; i < 20; i++) step(1'b1, rs(), rs(), rs(), rs(), "R9 post-reset", 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0, 0, 0, 0, 0, "drain", 1'b0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errs++;
            chks++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, chks);
            $finish;
        end
    end

endmodule